// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block takes 14-bit samples from a converter core, one per clock when a valid strobe is high, and prepares them for the output pins. Every valid sample runs through four steps in a fixed order: a signed offset from -32 to +31 codes is added and the result is held inside the code range; an optional test pattern may replace the sample; the value is then put into the selected output code (offset binary, two's complement or Gray); finally it is registered together with a valid strobe.

Samples are treated as offset-binary codes inside the block. Test patterns are inserted after the offset step, so they come out in the selected output code just like real data. A byte-wide register port with a combinational read path holds the code format, the offset, the pattern selection and a 14-bit custom pattern split over two byte registers. The alternating pattern is driven by a small state machine with three named states: `TG_IDLE` (the alternating pattern is not selected), `TG_ONES` (the next valid sample gives all ones) and `TG_ZEROS` (the next valid sample gives all zeros).

The state machine has these transitions:

- Any state moves to `TG_IDLE` when the alternating pattern is not selected.
- `TG_IDLE` moves to `TG_ZEROS` on a valid sample, or to `TG_ONES` with no sample.
- `TG_ONES` moves to `TG_ZEROS` on a valid sample.
- `TG_ZEROS` moves to `TG_ONES` on a valid sample.
- With no sample, `TG_ONES` and `TG_ZEROS` stay where they are.

Top module: `adc_fmt_top`

## Requirements
- R1: After reset `out_valid` and `out_data` are 0 and every register reads 0x00.
- R2: The register map is: format at address 0x11 bits 1:0; offset at 0x13 bits 5:0; pattern select at 0x14 bits 2:0; custom bits 13:6 at 0x15 bits 7:0; custom bits 5:0 at 0x16 bits 7:2. Unused bits read 0, and any other address reads 0x00 and ignores writes.
- R3: `out_valid` equals `smp_valid` delayed by one clock. `out_data` changes only in the clock after a valid sample, and otherwise holds its value.
- R4: The 6-bit two's-complement offset is added to the sample. The sum is clamped to the range 0 to 16383 instead of wrapping, and offset 000000 leaves the sample unchanged.
- R5: The pattern-select codes 001, 010 and 011 replace the sample with 8192, 0 and 16383 (before the format step).
- R6: Pattern-select code 100 gives 16383 and 0 alternately. It changes only on valid samples, and it starts at 16383 each time the code is newly selected.
- R7: Pattern-select code 101 outputs the custom word. Code 110 outputs 0x2AAA and code 111 outputs 0x1555 (before the format step).
- R8: The format codes 00 and 11 give offset binary. Code 01 inverts bit 13. Code 10 gives x XOR (x>>1).
- R9: A register write takes effect on the first sample after the write cycle. A sample in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 14 | Input sample, offset binary |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 14 | Formatted output sample |

## Verification
A formatted sample is due exactly one clock after its valid input: the bench drives inputs on the falling edge and compares `out_valid` and `out_data` against its own model on the next falling edge. Register reads are combinational, so they are checked in the same cycle as the address is applied. A write changes the model only after the sample of the same edge has been computed, so a write is seen by the first sample one cycle later. Because the model is compared on every clock, the hold of `out_data` between samples and the toggle's stalls on idle cycles are also checked.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        TG_IDLE  = 2'd0,
        TG_ONES  = 2'd1,
        TG_ZEROS = 2'd2
    } tog_state_t;

    typedef enum logic [2:0] {
        PAT_OFF    = 3'd0,
        PAT_MID    = 3'd1,
        PAT_NEGFS  = 3'd2,
        PAT_POSFS  = 3'd3,
        PAT_TOGGLE = 3'd4,
        PAT_CUSTOM = 3'd5,
        PAT_ALT10  = 3'd6,
        PAT_ALT01  = 3'd7
    } pat_sel_t;

    typedef enum logic [1:0] {
        FMT_OFFBIN  = 2'd0,
        FMT_TWOS    = 2'd1,
        FMT_GRAY    = 2'd2,
        FMT_OFFBIN2 = 2'd3
    } fmt_t;

    localparam logic [7:0] ADDR_FMT     = 8'h11;
    localparam logic [7:0] ADDR_OFFSET  = 8'h13;
    localparam logic [7:0] ADDR_PATSEL  = 8'h14;
    localparam logic [7:0] ADDR_CUST_HI = 8'h15;
    localparam logic [7:0] ADDR_CUST_LO = 8'h16;

endpackage

// File: rtl/adc_fmt_regs.sv
module adc_fmt_regs
    import adc_fmt_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int OFF_W = 6,
    parameter int LO_W  = 6,
    localparam int HI_W = SMP_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [1:0]       fmt_o,
    output logic [OFF_W-1:0] off_o,
    output logic [2:0]       sel_o,
    output logic [SMP_W-1:0] cust_o
);
    logic [1:0]       fmt_q;
    logic [OFF_W-1:0] off_q;
    logic [2:0]       sel_q;
    logic [HI_W-1:0]  hi_q;
    logic [LO_W-1:0]  lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= '0;
            off_q <= '0;
            sel_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_FMT:     fmt_q <= wdata[1:0];
                ADDR_OFFSET:  off_q <= wdata[OFF_W-1:0];
                ADDR_PATSEL:  sel_q <= wdata[2:0];
                ADDR_CUST_HI: hi_q  <= wdata[HI_W-1:0];
                ADDR_CUST_LO: lo_q  <= wdata[7 -: LO_W];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_FMT:     rdata[1:0]       = fmt_q;
            ADDR_OFFSET:  rdata[OFF_W-1:0] = off_q;
            ADDR_PATSEL:  rdata[2:0]       = sel_q;
            ADDR_CUST_HI: rdata[HI_W-1:0]  = hi_q;
            ADDR_CUST_LO: rdata[7 -: LO_W] = lo_q;
            default:      rdata            = '0;
        endcase
    end

    assign fmt_o  = fmt_q;
    assign off_o  = off_q;
    assign sel_o  = sel_q;
    assign cust_o = {hi_q, lo_q};
endmodule

// File: rtl/adc_fmt_offset.sv
module adc_fmt_offset #(
    parameter int SMP_W = 14,
    parameter int OFF_W = 6,
    localparam int SUM_W = SMP_W + 2
) (
    input  logic [SMP_W-1:0] din,
    input  logic [OFF_W-1:0] off,
    output logic [SMP_W-1:0] dout
);
    localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << SMP_W) - 1);

    logic signed [SUM_W-1:0] din_ext;
    logic signed [SUM_W-1:0] off_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        din_ext = $signed({2'b00, din});
        off_ext = $signed({{(SUM_W - OFF_W){off[OFF_W-1]}}, off});
        sum     = din_ext + off_ext;
        if (sum < 0)
            dout = '0;
        else if (sum > CODE_MAX)
            dout = '1;
        else
            dout = sum[SMP_W-1:0];
    end
endmodule

// File: rtl/adc_fmt_pattern.sv
module adc_fmt_pattern
    import adc_fmt_pkg::*;
#(
    parameter int SMP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [2:0]       sel,
    input  logic [SMP_W-1:0] cust,
    input  logic [SMP_W-1:0] din,
    output logic [SMP_W-1:0] dout
);
    localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

    tog_state_t state_q, state_d;
    pat_sel_t   mode;
    logic [SMP_W-1:0] alt10;

    for (genvar i = 0; i < SMP_W; i++) begin : g_alt
        assign alt10[i] = (i % 2) == 1;
    end

    assign mode = pat_sel_t'(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        dout    = din;
        if (mode != PAT_TOGGLE) begin
            state_d = TG_IDLE;
        end else begin
            unique case (state_q)
                TG_IDLE:  state_d = valid ? TG_ZEROS : TG_ONES;
                TG_ONES:  state_d = valid ? TG_ZEROS : TG_ONES;
                TG_ZEROS: state_d = valid ? TG_ONES  : TG_ZEROS;
                default:  state_d = TG_IDLE;
            endcase
        end
        unique case (mode)
            PAT_OFF:    dout = din;
            PAT_MID:    dout = MID;
            PAT_NEGFS:  dout = '0;
            PAT_POSFS:  dout = '1;
            PAT_TOGGLE: dout = (state_q == TG_ZEROS) ? '0 : '1;
            PAT_CUSTOM: dout = cust;
            PAT_ALT10:  dout = alt10;
            PAT_ALT01:  dout = ~alt10;
            default:    dout = din;
        endcase
    end
endmodule

// File: rtl/adc_fmt_top.sv
module adc_fmt_top
    import adc_fmt_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data
);
    logic [1:0]       cfg_fmt;
    logic [OFF_W-1:0] cfg_off;
    logic [2:0]       cfg_sel;
    logic [SMP_W-1:0] cfg_cust;
    logic [SMP_W-1:0] adj_data;
    logic [SMP_W-1:0] pat_data;
    logic [SMP_W-1:0] enc_data;

    adc_fmt_regs #(.SMP_W(SMP_W), .OFF_W(OFF_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .fmt_o  (cfg_fmt),
        .off_o  (cfg_off),
        .sel_o  (cfg_sel),
        .cust_o (cfg_cust)
    );

    adc_fmt_offset #(.SMP_W(SMP_W), .OFF_W(OFF_W)) u_offset (
        .din  (smp_data),
        .off  (cfg_off),
        .dout (adj_data)
    );

    adc_fmt_pattern #(.SMP_W(SMP_W)) u_pattern (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (smp_valid),
        .sel   (cfg_sel),
        .cust  (cfg_cust),
        .din   (adj_data),
        .dout  (pat_data)
    );

    always_comb begin
        unique case (fmt_t'(cfg_fmt))
            FMT_TWOS: enc_data = {~pat_data[SMP_W-1], pat_data[SMP_W-2:0]};
            FMT_GRAY: enc_data = pat_data ^ (pat_data >> 1);
            default:  enc_data = pat_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid)
                out_data <= enc_data;
        end
    end
endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
    parameter int SMP_W = 14,
    parameter int OFF_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic             out_valid,
    input logic [SMP_W-1:0] out_data,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic [1:0]       fmt,
    input logic [2:0]       sel,
    input logic [OFF_W-1:0] off
);
    localparam logic [SMP_W-1:0] TWOS_POSFS = {1'b0, {(SMP_W-1){1'b1}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid); // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid); // R3
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(out_data)); // R3
    AST_FMT_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h11) |-> (reg_rdata[7:2] == 6'd0)); // R2
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && sel == 3'd0 && fmt == 2'd0 && !off[OFF_W-1] && (&smp_data))
        |=> (&out_data)); // R4
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && sel == 3'd0 && fmt == 2'd0 && off[OFF_W-1] && smp_data == '0)
        |=> (out_data == '0)); // R4
    AST_POSFS_TWOS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && sel == 3'd3 && fmt == 2'd1) |=> (out_data == TWOS_POSFS)); // R5
endmodule

bind adc_fmt_top adc_fmt_chk #(.SMP_W(SMP_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .fmt       (cfg_fmt),
    .sel       (cfg_sel),
    .off       (cfg_off)
);

// File: tb/adc_fmt_top_tb_top.sv
module adc_fmt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_data = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        out_valid;
    logic [13:0] out_data;

    always #5 clk = ~clk;

    adc_fmt_top dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural model state
    int    m_fmt, m_off, m_sel, m_chi, m_clo;
    bit    m_ones_next;
    bit    m_v;
    int    m_d;
    string m_tag = "R1";

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_sample(int d);
        int offs = (m_off >= 32) ? m_off - 64 : m_off;
        int x = d + offs;
        if (x < 0) x = 0;
        if (x > 16383) x = 16383;
        case (m_sel)
            1: x = 8192;
            2: x = 0;
            3: x = 16383;
            4: begin x = m_ones_next ? 16383 : 0; m_ones_next = !m_ones_next; end
            5: x = m_chi * 64 + m_clo;
            6: x = 'h2AAA;
            7: x = 'h1555;
            default: ;
        endcase
        if (m_fmt == 1) x = x ^ 8192;
        else if (m_fmt == 2) x = x ^ (x >> 1);
        return x;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fmt = 0; m_off = 0; m_sel = 0; m_chi = 0; m_clo = 0;
            m_ones_next = 1; m_v = 0; m_d = 0; m_tag = "R1";
        end else begin
            if (smp_valid) begin
                if (m_sel == 4) m_tag = "R6";
                else if (m_sel >= 5) m_tag = "R7";
                else if (m_sel != 0) m_tag = "R5";
                else if (m_fmt != 0) m_tag = "R8";
                else if (m_off != 0) m_tag = "R4";
                else m_tag = "R3";
                m_d = model_sample(int'(smp_data));
                m_v = 1;
            end else begin
                m_v = 0;
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h11: m_fmt = reg_wdata & 3;
                    8'h13: m_off = reg_wdata & 63;
                    8'h14: begin
                        if ((reg_wdata & 7) == 4 && m_sel != 4) m_ones_next = 1;
                        m_sel = reg_wdata & 7;
                    end
                    8'h15: m_chi = reg_wdata;
                    8'h16: m_clo = reg_wdata >> 2;
                    default: ;
                endcase
            end
        end
    end

    // compare against model every clock
    always @(negedge clk) begin
        if (rst_n) begin
            check(out_valid == m_v, "R3 valid", int'(out_valid), int'(m_v));
            check(int'(out_data) == m_d, m_tag, int'(out_data), m_d);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
    endtask

    task automatic samp(input int d);
        @(negedge clk);
        smp_valid = 1; smp_data = 14'(d);
        @(negedge clk);
        smp_valid = 0;
    endtask

    task automatic samp_exp(input int d, input int exp, input string tag);
        samp(d);
        #1;
        check(int'(out_data) == exp, tag, int'(out_data), exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R1 valid", int'(out_valid), 0);
        check(out_data == 0, "R1 data", int'(out_data), 0);
        rst_n = 1;
        rd_chk(8'h11, 0, "R1"); rd_chk(8'h13, 0, "R1"); rd_chk(8'h14, 0, "R1");
        rd_chk(8'h15, 0, "R1"); rd_chk(8'h16, 0, "R1");

        // R2 field positions and unused bits
        wr(8'h11, 8'hFF); rd_chk(8'h11, 8'h03, "R2");
        wr(8'h13, 8'hFF); rd_chk(8'h13, 8'h3F, "R2");
        wr(8'h14, 8'hFB); rd_chk(8'h14, 8'h03, "R2");
        wr(8'h15, 8'hA5); rd_chk(8'h15, 8'hA5, "R2");
        wr(8'h16, 8'hFF); rd_chk(8'h16, 8'hFC, "R2");
        wr(8'h12, 8'hFF); rd_chk(8'h12, 0, "R2");
        rd_chk(8'h11, 8'h03, "R2 other address write ignored");
        wr(8'h11, 0); wr(8'h13, 0); wr(8'h14, 0);

        // R3 passthrough and hold
        samp_exp(1234, 1234, "R3");
        @(negedge clk); #1;
        check(out_valid == 0, "R3 no valid", int'(out_valid), 0);
        check(out_data == 1234, "R3 hold", int'(out_data), 1234);
        samp_exp(16383, 16383, "R3");

        // R4 offset and clamp
        wr(8'h13, 8'd31);   samp_exp(16380, 16383, "R4 clamp high");
        samp_exp(100, 131, "R4 plus");
        wr(8'h13, 8'h20);   samp_exp(10, 0, "R4 clamp low");
        wr(8'h13, 8'h3F);   samp_exp(100, 99, "R4 minus one");
        wr(8'h13, 0);       samp_exp(100, 100, "R4 zero");

        // R8 formats
        wr(8'h11, 1); samp_exp(0, 8192, "R8 twos"); samp_exp(16383, 8191, "R8 twos");
        wr(8'h11, 2); samp_exp(5, 7, "R8 gray"); samp_exp(8192, 12288, "R8 gray");
        wr(8'h11, 3); samp_exp(5, 5, "R8 code 11");
        wr(8'h11, 0);

        // R5 fixed patterns
        wr(8'h14, 1); samp_exp(77, 8192, "R5 mid");
        wr(8'h14, 2); samp_exp(77, 0, "R5 negfs");
        wr(8'h14, 3); samp_exp(77, 16383, "R5 posfs");
        wr(8'h11, 1); samp_exp(77, 8191, "R5 posfs twos");
        wr(8'h11, 0);

        // R6 alternating pattern
        wr(8'h14, 4);
        samp_exp(1, 16383, "R6 first");
        repeat (3) @(negedge clk);
        samp_exp(1, 0, "R6 second");
        samp_exp(1, 16383, "R6 third");
        wr(8'h14, 4);
        samp_exp(1, 0, "R6 rewrite same code");
        wr(8'h14, 0); samp_exp(7, 7, "R6 off");
        wr(8'h14, 4); samp_exp(7, 16383, "R6 restart");

        // R7 custom and alternating-bit words
        wr(8'h15, 8'hA5); wr(8'h16, 8'hFC);
        wr(8'h14, 5); samp_exp(0, 10623, "R7 custom");
        wr(8'h14, 6); samp_exp(0, 'h2AAA, "R7 1010");
        wr(8'h14, 7); samp_exp(0, 'h1555, "R7 0101");
        wr(8'h14, 0);

        // R9 write and sample in the same cycle
        @(negedge clk);
        smp_valid = 1; smp_data = 14'd100;
        reg_we = 1; reg_addr = 8'h13; reg_wdata = 8'd5;
        @(negedge clk);
        smp_valid = 0; reg_we = 0; #1;
        check(out_data == 100, "R9 old setting", int'(out_data), 100);
        samp_exp(100, 105, "R9 new setting");

        // mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            smp_valid = ($urandom % 3) != 0;
            smp_data = 14'($urandom);
            reg_we = ($urandom % 4) == 0;
            case ($urandom % 6)
                0: reg_addr = 8'h11;
                1: reg_addr = 8'h13;
                2: reg_addr = 8'h14;
                3: reg_addr = 8'h15;
                4: reg_addr = 8'h16;
                default: reg_addr = 8'h40;
            endcase
            reg_wdata = 8'($urandom);
        end
        @(negedge clk);
        smp_valid = 0; reg_we = 0;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule